// File: doc/BRIEF.md
# Memory PHY Reset Sequencer

This block produces every reset that a memory PHY needs. It takes two asynchronous active-low requests, a chip-wide reset and a software reset, together with the lock flag of the PHY's PLL. From these it derives an active-high reset for the PLL and three active-low resets, one for each clock domain: the PHY core clock, the clock-divider clock and a reconfiguration/scan clock. Every domain reset asserts at once, without waiting for a clock. It releases only after a chain of flops clocked in its own domain has filled.

The PHY core reset combines the chip-wide reset, the software reset and PLL lock. The divider reset has a synchronizer of its own. That synchronizer never sees the software reset, so a software reset leaves the divider clock running undisturbed. The scan domain follows only the chip-wide reset, because its clock does not come from the PLL. An optional unit clocked by the PLL reference clock watches an active-low request line. When it sees a falling edge, it holds the whole reset tree asserted for a fixed number of reference cycles. This works as though the chip-wide reset had been pulled.

Top module: `rstm_top`

## Requirements
- R1: While `global_rst_n` is low, `pll_rst` is high, and it goes high at the same time as `global_rst_n` falls, with no clock edge needed.
- R2: `phy_rst_n` is low whenever `global_rst_n`, `soft_rst_n` or `pll_locked` is low, and it falls at once when any of them falls.
- R3: `soft_rst_n` has no effect on `div_rst_n`. Only `global_rst_n`, a request stretch or loss of lock drives it low.
- R4: `scan_rst_n` is low whenever `global_rst_n` is low or a request stretch is running. It does not depend on `soft_rst_n` or `pll_locked`. It rises on the 2nd rising `scan_clk` edge at which its reset source is inactive.
- R5: `phy_rst_n` rises on the (2 + PIPE_STAGES)th rising `phy_clk` edge at which `global_rst_n`, `soft_rst_n` and `pll_locked` are all high. With the default of 4 pipe stages, this is the 6th edge.
- R6: `div_rst_n` is low while `pll_locked` is low. It rises on the (2 + PIPE_STAGES)th rising `div_clk` edge at which `global_rst_n` and `pll_locked` are both high.
- R7: If `pll_locked` falls while the PHY is running, `phy_rst_n` falls at once. After lock returns, it releases only after the full pipe latency of R5.
- R8: A falling edge on `req_rst_n` raises `pll_rst` at the 3rd rising `ref_clk` edge after the fall. `pll_rst` then stays high for exactly STRETCH_CYCLES reference cycles (default 16). During that time, `phy_rst_n`, `div_rst_n` and `scan_rst_n` are all low.
- R9: Only the falling edge of `req_rst_n` counts. Holding it low does not extend or restart the stretch, and its rising edge has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | PLL reference clock, drives the request stretch unit |
| phy_clk | input | 1 | PHY core clock |
| div_clk | input | 1 | Clock-divider clock |
| scan_clk | input | 1 | Reconfiguration/scan clock |
| global_rst_n | input | 1 | Chip-wide asynchronous reset, active low |
| soft_rst_n | input | 1 | Software asynchronous reset, active low |
| req_rst_n | input | 1 | Reset request, active low, acted on at its falling edge |
| pll_locked | input | 1 | PLL lock flag |
| pll_rst | output | 1 | PLL reset, active high |
| phy_rst_n | output | 1 | PHY core domain reset, active low |
| div_rst_n | output | 1 | Clock-divider domain reset, active low |
| scan_rst_n | output | 1 | Scan/reconfiguration domain reset, active low |

## Verification
The assertions assume that `pll_locked` only claims lock while the PLL reset is low. They also assume that `soft_rst_n` and `pll_locked` change independently of the chip-wide reset, so that the soft-reset and lock properties can be switched off while `pll_rst` is high. The stimulus follows these assumptions. It toggles the chip-wide reset, soft reset and lock at random, but always a few nanoseconds away from any clock edge. It holds the request line idle while the random phase runs and pulses it only in directed sequences. The bench's per-domain edge counters are therefore a valid expectation at every sample.

// File: rtl/rstm_pkg.sv
package rstm_pkg;

    // Clock domains served by the sequencer; the index selects the clock.
    typedef enum int {
        DOM_PHY  = 0,
        DOM_DIV  = 1,
        DOM_SCAN = 2
    } rstm_dom_e;

    localparam int NUM_DOM     = 3;
    localparam int SYNC_STAGES = 2;

    // Release pipe stages appended after the synchronizer of a domain.
    function automatic int dom_pipe(input int dom, input int pipe_stages);
        return (dom == DOM_SCAN) ? 0 : pipe_stages;
    endfunction

    // Counter width able to hold the value n.
    function automatic int cnt_width(input int n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/rstm_chain.sv
module rstm_chain #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    input  logic din_n,
    output logic rst_n
);
    logic [STAGES-1:0] stage_q;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            stage_q <= '0;
        end else begin
            stage_q <= {stage_q[STAGES-2:0], din_n};
        end
    end

    assign rst_n = stage_q[STAGES-1];
endmodule

// File: rtl/rstm_req_stretch.sv
module rstm_req_stretch #(
    parameter int STRETCH_CYCLES = 16
) (
    input  logic ref_clk,
    input  logic arst_n,
    input  logic req_rst_n,
    output logic busy
);
    localparam int CW = rstm_pkg::cnt_width(STRETCH_CYCLES);

    typedef struct packed {
        logic [2:0]    smp;   // two sync flops and one history flop
        logic [CW-1:0] cnt;
    } stretch_t;

    stretch_t st_q, st_d;
    logic     fall_seen;

    assign fall_seen = st_q.smp[2] && !st_q.smp[1];

    always_comb begin
        st_d     = st_q;
        st_d.smp = {st_q.smp[1:0], req_rst_n};
        if (fall_seen) begin
            st_d.cnt = CW'(STRETCH_CYCLES);
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge ref_clk or negedge arst_n) begin
        if (!arst_n) begin
            st_q.smp <= '1;
            st_q.cnt <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy = (st_q.cnt != '0);
endmodule

// File: rtl/rstm_top.sv
module rstm_top #(
    parameter int PIPE_STAGES    = 4,
    parameter int STRETCH_CYCLES = 16,
    parameter bit REQ_EN         = 1'b1
) (
    input  logic ref_clk,
    input  logic phy_clk,
    input  logic div_clk,
    input  logic scan_clk,
    input  logic global_rst_n,
    input  logic soft_rst_n,
    input  logic req_rst_n,
    input  logic pll_locked,
    output logic pll_rst,
    output logic phy_rst_n,
    output logic div_rst_n,
    output logic scan_rst_n
);
    import rstm_pkg::*;

    logic                stretch_busy;
    logic                master_n;
    logic [NUM_DOM-1:0]  dom_clk;
    logic [NUM_DOM-1:0]  dom_arst_n;
    logic [NUM_DOM-1:0]  dom_rst_n;

    generate
        if (REQ_EN) begin : g_req
            rstm_req_stretch #(.STRETCH_CYCLES(STRETCH_CYCLES)) i_stretch (
                .ref_clk   (ref_clk),
                .arst_n    (global_rst_n),
                .req_rst_n (req_rst_n),
                .busy      (stretch_busy)
            );
        end else begin : g_noreq
            assign stretch_busy = 1'b0;
        end
    endgenerate

    // Chip-wide reset, extended by a request stretch.
    assign master_n = global_rst_n && !stretch_busy;
    assign pll_rst  = !master_n;

    assign dom_clk[DOM_PHY]  = phy_clk;
    assign dom_clk[DOM_DIV]  = div_clk;
    assign dom_clk[DOM_SCAN] = scan_clk;

    // The divider source never sees the soft reset.
    assign dom_arst_n[DOM_PHY]  = master_n && soft_rst_n && pll_locked;
    assign dom_arst_n[DOM_DIV]  = master_n && pll_locked;
    assign dom_arst_n[DOM_SCAN] = master_n;

    generate
        for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
            localparam int PIPE_D = dom_pipe(d, PIPE_STAGES);
            logic sync_n;

            rstm_chain #(.STAGES(SYNC_STAGES)) i_sync (
                .clk    (dom_clk[d]),
                .arst_n (dom_arst_n[d]),
                .din_n  (1'b1),
                .rst_n  (sync_n)
            );

            if (PIPE_D >= 2) begin : g_pipe
                rstm_chain #(.STAGES(PIPE_D)) i_pipe (
                    .clk    (dom_clk[d]),
                    .arst_n (dom_arst_n[d]),
                    .din_n  (sync_n),
                    .rst_n  (dom_rst_n[d])
                );
            end else if (PIPE_D == 1) begin : g_one
                logic one_q;
                always_ff @(posedge dom_clk[d] or negedge dom_arst_n[d]) begin
                    if (!dom_arst_n[d]) one_q <= 1'b0;
                    else                one_q <= sync_n;
                end
                assign dom_rst_n[d] = one_q;
            end else begin : g_nopipe
                assign dom_rst_n[d] = sync_n;
            end
        end
    endgenerate

    assign phy_rst_n  = dom_rst_n[DOM_PHY];
    assign div_rst_n  = dom_rst_n[DOM_DIV];
    assign scan_rst_n = dom_rst_n[DOM_SCAN];
endmodule

// File: rtl/rstm_checks.sv
module rstm_checks (
    input logic ref_clk,
    input logic phy_clk,
    input logic div_clk,
    input logic scan_clk,
    input logic global_rst_n,
    input logic soft_rst_n,
    input logic pll_locked,
    input logic pll_rst,
    input logic phy_rst_n,
    input logic div_rst_n,
    input logic scan_rst_n
);
    always @(negedge ref_clk) begin
        if (global_rst_n === 1'b0) begin
            assert_pll_on_global_R1: assert (pll_rst === 1'b1);
        end
    end

    assert_phy_gated_R2: assert property (@(posedge phy_clk) disable iff (pll_rst)
        (!soft_rst_n || !pll_locked) |-> !phy_rst_n);

    assert_div_ignores_soft_R3: assert property (@(posedge div_clk) disable iff (pll_rst || !pll_locked)
        div_rst_n |=> div_rst_n);

    assert_scan_follows_R4: assert property (@(posedge scan_clk) disable iff (!global_rst_n)
        pll_rst |-> !scan_rst_n);

    assert_phy_release_R5: assert property (@(posedge phy_clk) disable iff (pll_rst)
        $rose(phy_rst_n) |-> $past(soft_rst_n && pll_locked));

    assert_div_lock_R6: assert property (@(posedge div_clk) disable iff (pll_rst)
        !pll_locked |-> !div_rst_n);

    assert_stretch_holds_R8: assert property (@(posedge ref_clk) disable iff (!global_rst_n)
        pll_rst |-> (!phy_rst_n && !div_rst_n));
endmodule

bind rstm_top rstm_checks i_rstm_checks (
    .ref_clk      (ref_clk),
    .phy_clk      (phy_clk),
    .div_clk      (div_clk),
    .scan_clk     (scan_clk),
    .global_rst_n (global_rst_n),
    .soft_rst_n   (soft_rst_n),
    .pll_locked   (pll_locked),
    .pll_rst      (pll_rst),
    .phy_rst_n    (phy_rst_n),
    .div_rst_n    (div_rst_n),
    .scan_rst_n   (scan_rst_n)
);

// File: tb/test_rstm_top.sv
`timescale 1ns/1ps
module test_rstm_top;
    localparam int PIPE    = 4;
    localparam int STRETCH = 16;
    localparam int PHY_LAT = 2 + PIPE;
    localparam int DIV_LAT = 2 + PIPE;
    localparam int SCN_LAT = 2;

    logic ref_clk = 1'b0, phy_clk = 1'b0, div_clk = 1'b0, scan_clk = 1'b0;
    logic global_rst_n, soft_rst_n, req_rst_n, pll_locked;
    logic pll_rst, phy_rst_n, div_rst_n, scan_rst_n;

    int checks = 0;
    int errors = 0;
    bit model_on = 1'b0;
    bit done = 1'b0;

    always #10 ref_clk  = ~ref_clk;   // 50 MHz
    always #10 phy_clk  = ~phy_clk;
    always #20 div_clk  = ~div_clk;
    always #15 scan_clk = ~scan_clk;

    rstm_top #(.PIPE_STAGES(PIPE), .STRETCH_CYCLES(STRETCH), .REQ_EN(1'b1)) i_rstm_top (
        .ref_clk(ref_clk), .phy_clk(phy_clk), .div_clk(div_clk), .scan_clk(scan_clk),
        .global_rst_n(global_rst_n), .soft_rst_n(soft_rst_n), .req_rst_n(req_rst_n),
        .pll_locked(pll_locked), .pll_rst(pll_rst), .phy_rst_n(phy_rst_n),
        .div_rst_n(div_rst_n), .scan_rst_n(scan_rst_n)
    );

    // Reference model: per-domain count of qualifying edges (request idle).
    wire m_phy_src = global_rst_n & soft_rst_n & pll_locked;
    wire m_div_src = global_rst_n & pll_locked;
    wire m_scn_src = global_rst_n;
    int m_phy_cnt, m_div_cnt, m_scn_cnt;

    always @(posedge phy_clk or negedge m_phy_src)
        if (!m_phy_src) m_phy_cnt <= 0; else if (m_phy_cnt < PHY_LAT) m_phy_cnt <= m_phy_cnt + 1;
    always @(posedge div_clk or negedge m_div_src)
        if (!m_div_src) m_div_cnt <= 0; else if (m_div_cnt < DIV_LAT) m_div_cnt <= m_div_cnt + 1;
    always @(posedge scan_clk or negedge m_scn_src)
        if (!m_scn_src) m_scn_cnt <= 0; else if (m_scn_cnt < SCN_LAT) m_scn_cnt <= m_scn_cnt + 1;

    function automatic logic exp_phy();  return m_phy_cnt >= PHY_LAT; endfunction
    function automatic logic exp_div();  return m_div_cnt >= DIV_LAT; endfunction
    function automatic logic exp_scan(); return m_scn_cnt >= SCN_LAT; endfunction

    task automatic check(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic compare_model();
        check("R1", "pll_rst", pll_rst, !global_rst_n);
        check("R5", "phy_rst_n", phy_rst_n, exp_phy());
        check("R6", "div_rst_n", div_rst_n, exp_div());
        check("R4", "scan_rst_n", scan_rst_n, exp_scan());
    endtask

    // Drive point: 3 ns after a phy edge; sample point: 7 ns after it.
    task automatic to_drive(); @(posedge phy_clk); #3; endtask
    task automatic sample();
        @(posedge phy_clk); #7;
        if (model_on) compare_model();
    endtask
    task automatic run(input int n);
        for (int i = 0; i < n; i++) sample();
    endtask

    initial begin
        #4_000_000;
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int k_up;
        void'($urandom(32'd20240611));
        global_rst_n = 1'b0; soft_rst_n = 1'b0; req_rst_n = 1'b1; pll_locked = 1'b0;

        // Reset state
        @(posedge phy_clk); #7;
        check("R1", "reset pll_rst", pll_rst, 1'b1);
        check("R2", "reset phy_rst_n", phy_rst_n, 1'b0);
        check("R3", "reset div_rst_n", div_rst_n, 1'b0);
        check("R4", "reset scan_rst_n", scan_rst_n, 1'b0);
        model_on = 1'b1;

        // Release global only: lock low keeps PHY and divider held
        to_drive(); global_rst_n = 1'b1; soft_rst_n = 1'b1;
        run(20);
        check("R6", "div held before lock", div_rst_n, 1'b0);
        check("R2", "phy held before lock", phy_rst_n, 1'b0);

        // Lock arrives: phy releases after exactly PHY_LAT edges
        to_drive(); pll_locked = 1'b1;
        k_up = 0;
        for (int k = 1; k <= PHY_LAT + 2; k++) begin
            sample();
            if (phy_rst_n && k_up == 0) k_up = k;
        end
        check("R5", "phy release edge", (k_up == PHY_LAT), 1'b1);
        run(12);

        // Soft reset alone: divider must stay released
        to_drive(); soft_rst_n = 1'b0; #4;
        check("R2", "phy on soft", phy_rst_n, 1'b0);
        for (int k = 0; k < 10; k++) begin
            sample();
            check("R3", "div under soft", div_rst_n, 1'b1);
        end
        to_drive(); soft_rst_n = 1'b1;
        run(10);

        // Lock loss while running
        to_drive(); pll_locked = 1'b0; #4;
        check("R7", "phy on lock loss", phy_rst_n, 1'b0);
        run(3);
        to_drive(); pll_locked = 1'b1;
        k_up = 0;
        for (int k = 1; k <= PHY_LAT + 2; k++) begin
            sample();
            if (phy_rst_n && k_up == 0) k_up = k;
        end
        check("R7", "phy relock latency", (k_up == PHY_LAT), 1'b1);
        run(12);

        // Request stretch
        model_on = 1'b0;
        to_drive(); req_rst_n = 1'b0;
        for (int k = 1; k <= STRETCH + 4; k++) begin
            @(posedge phy_clk); #7;
            check("R8", "pll_rst during stretch", pll_rst, (k >= 3 && k <= STRETCH + 2));
            if (k == 4) begin
                check("R8", "phy in stretch", phy_rst_n, 1'b0);
                check("R8", "div in stretch", div_rst_n, 1'b0);
                check("R8", "scan in stretch", scan_rst_n, 1'b0);
            end
        end
        for (int k = 0; k < 10; k++) begin
            @(posedge phy_clk); #7;
            check("R9", "held request no retrigger", pll_rst, 1'b0);
        end
        run(16);
        to_drive(); req_rst_n = 1'b1;
        for (int k = 0; k < 10; k++) begin
            @(posedge phy_clk); #7;
            check("R9", "rising request pll_rst", pll_rst, 1'b0);
            check("R9", "rising request phy_rst_n", phy_rst_n, 1'b1);
        end
        model_on = 1'b1;

        // Random phase
        for (int it = 0; it < 300; it++) begin
            int r;
            r = int'($urandom % 16);
            to_drive();
            if (!global_rst_n) global_rst_n = (r < 12);
            else if (r == 0) global_rst_n = 1'b0;
            else if (r < 4) soft_rst_n = ~soft_rst_n;
            else if (r < 7) pll_locked = ~pll_locked;
            #4;
            compare_model();
            run(1 + int'($urandom % 10));
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule